// File: doc/BRIEF.md
# Strided Vector Move/Swap Engine

This block is a small sequencer that walks two strided vectors held in a single-port word memory. Either it copies every element of the first vector onto the matching element of the second, or it exchanges the two. An element is a group of 2 words in single precision or 4 words in double precision. Each vector has its own base address and its own signed stride, counted in elements.

A job starts with a one-cycle `start_i` pulse while the engine is idle. The bases, strides, count and mode bits are captured at that moment. For each index the engine reads the whole first element, then the whole second element, and only then writes. It writes the second location first. In swap mode it then writes the first location. It drives the memory port on every busy cycle, raises `done_o` for one cycle once the job is over, and returns to idle.

Top module: `vec_xfer_engine`

## Requirements
- R1: An element is 2 words when `dbl_i`=0 and 4 words when `dbl_i`=1. The words of one element are accessed on consecutive cycles at addresses base+0, base+1, and so on upward.
- R2: After each element, each vector address advances by its own signed stride multiplied by the element size. The address wraps modulo 2^AW.
- R3: A start with a count of zero or less (count read as two's complement) causes no memory access. In that case `done_o` is high in the cycle after the start is sampled, and `busy_o` stays low.
- R4: For each index, all reads of the vector 1 element come first, then all reads of the vector 2 element, then the writes of the vector 1 data into the vector 2 location.
- R5: When `swap_i`=1, the saved vector 2 data is written into the vector 1 location after the vector 2 writes. When `swap_i`=0, vector 1 is never written.
- R6: Move mode still reads the vector 2 element, and it discards that data.
- R7: Read data on `mem_rdata_i` is taken one cycle after the read request. The port is busy on every cycle of a job, so one element costs 3×size cycles in move mode and 4×size cycles in swap mode.
- R8: `done_o` is a one-cycle pulse in the cycle after the last write. `busy_o` is low whenever `done_o` is high, and no memory request is made while `busy_o` is low.
- R9: A `start_i` pulse while busy is ignored. The running job's accesses are unchanged and no second job follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled only when idle |
| swap_i | input | 1 | 1 = exchange elements, 0 = copy vector 1 to vector 2 |
| dbl_i | input | 1 | 1 = 4-word elements, 0 = 2-word elements |
| v1_base_i | input | AW | Word address of the first element of vector 1 |
| v1_stride_i | input | SW | Signed stride of vector 1, in elements |
| v2_base_i | input | AW | Word address of the first element of vector 2 |
| v2_stride_i | input | SW | Signed stride of vector 2, in elements |
| count_i | input | CW | Signed element count |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid one cycle after a read request |

## Verification
The hardest case to reach from the ports is a swap where the two vectors interact. Here a later element rereads a word that an earlier element of the same job has already rewritten. The stimulus forces this with a zero stride on vector 2, so the same location is swapped in again on each index. It also uses a negative stride on vector 1. The outcome then depends on reading both elements before any write and on the fixed write order. A second hard case is a start pulse landing in the middle of a job. The bench pulses start several cycles into a running transfer with different bases and count, then checks that the access trace and the done count match the first job alone.

// File: rtl/vxe_pkg.sv
package vxe_pkg;
  localparam int unsigned MAX_WORDS = 4;
  localparam int unsigned IDX_W     = $clog2(MAX_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_WR2,
    ST_WR1
  } vxe_state_e;
endpackage

// File: rtl/vxe_addr_gen.sv
module vxe_addr_gen #(
  parameter int unsigned AW = 16,
  parameter int unsigned SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          dbl_i,
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] stride_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;
  logic [SW-1:0] stride_q;
  logic signed [AW-1:0] stride_ext;
  logic [AW-1:0] step_amt;

  assign stride_ext = AW'($signed(stride_q));
  // stride scaled by element size: x2 or x4
  assign step_amt   = dbl_i ? AW'(stride_ext <<< 2) : AW'(stride_ext <<< 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      stride_q <= '0;
    end else if (load_i) begin
      addr_q   <= base_i;
      stride_q <= stride_i;
    end else if (step_i) begin
      addr_q   <= addr_q + step_amt;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/vxe_elem_buf.sv
module vxe_elem_buf
  import vxe_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             cap_bank_i,
  input  logic [IDX_W-1:0] cap_idx_i,
  input  logic [DW-1:0]    cap_data_i,
  input  logic             rd_bank_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o
);
  logic [DW-1:0] store_q [2][MAX_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < int'(MAX_WORDS); w++)
          store_q[b][w] <= '0;
    end else if (cap_i) begin
      store_q[cap_bank_i][cap_idx_i] <= cap_data_i;
    end
  end

  assign rd_data_o = store_q[rd_bank_i][rd_idx_i];
endmodule

// File: rtl/vxe_seq.sv
module vxe_seq
  import vxe_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             swap_i,
  input  logic             dbl_i,
  input  logic [CW-1:0]    count_i,
  output vxe_state_e       state_o,
  output logic [IDX_W-1:0] widx_o,
  output logic             dbl_o,
  output logic             load_o,
  output logic             step_o,
  output logic             busy_o,
  output logic             done_o
);
  vxe_state_e       state_q;
  logic [IDX_W-1:0] widx_q;
  logic [CW-1:0]    rem_q;
  logic             swap_q, dbl_q, done_q;
  logic             last_word, elem_end;

  assign last_word = (widx_q == (dbl_q ? IDX_W'(3) : IDX_W'(1)));
  assign elem_end  = last_word && ((state_q == ST_WR1) || (state_q == ST_WR2 && !swap_q));
  assign load_o    = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      rem_q   <= '0;
      swap_q  <= 1'b0;
      dbl_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            swap_q <= swap_i;
            dbl_q  <= dbl_i;
            rem_q  <= count_i;
            widx_q <= '0;
            if ($signed(count_i) > 0) state_q <= ST_RD1;
            else                       done_q  <= 1'b1;
          end
        end
        ST_RD1: begin
          widx_q <= last_word ? '0 : widx_q + 1'b1;
          if (last_word) state_q <= ST_RD2;
        end
        ST_RD2: begin
          widx_q <= last_word ? '0 : widx_q + 1'b1;
          if (last_word) state_q <= ST_WR2;
        end
        ST_WR2, ST_WR1: begin
          widx_q <= last_word ? '0 : widx_q + 1'b1;
          if (last_word && state_q == ST_WR2 && swap_q) begin
            state_q <= ST_WR1;
          end else if (elem_end) begin
            if (rem_q == CW'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              rem_q   <= rem_q - 1'b1;
              state_q <= ST_RD1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign widx_o  = widx_q;
  assign dbl_o   = dbl_q;
  assign step_o  = elem_end;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/vec_xfer_engine.sv
module vec_xfer_engine
  import vxe_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          swap_i,
  input  logic          dbl_i,
  input  logic [AW-1:0] v1_base_i,
  input  logic [SW-1:0] v1_stride_i,
  input  logic [AW-1:0] v2_base_i,
  input  logic [SW-1:0] v2_stride_i,
  input  logic [CW-1:0] count_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int unsigned NVEC = 2;

  vxe_state_e       state;
  logic [IDX_W-1:0] widx;
  logic             dbl_q, load, step;
  logic [AW-1:0]    vaddr [NVEC];

  vxe_seq #(.CW(CW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .swap_i  (swap_i),
    .dbl_i   (dbl_i),
    .count_i (count_i),
    .state_o (state),
    .widx_o  (widx),
    .dbl_o   (dbl_q),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  for (genvar g = 0; g < NVEC; g++) begin : g_vec
    vxe_addr_gen #(.AW(AW), .SW(SW)) u_ag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .step_i   (step),
      .dbl_i    (dbl_q),
      .base_i   ((g == 0) ? v1_base_i : v2_base_i),
      .stride_i ((g == 0) ? v1_stride_i : v2_stride_i),
      .addr_o   (vaddr[g])
    );
  end

  // read return tracking: data lands one cycle after the request
  logic             cap_v_q, cap_bank_q;
  logic [IDX_W-1:0] cap_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_v_q    <= 1'b0;
      cap_bank_q <= 1'b0;
      cap_idx_q  <= '0;
    end else begin
      cap_v_q    <= (state == ST_RD1) || (state == ST_RD2);
      cap_bank_q <= (state == ST_RD2);
      cap_idx_q  <= widx;
    end
  end

  vxe_elem_buf #(.DW(DW)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap_v_q),
    .cap_bank_i (cap_bank_q),
    .cap_idx_i  (cap_idx_q),
    .cap_data_i (mem_rdata_i),
    .rd_bank_i  (state == ST_WR1),
    .rd_idx_i   (widx),
    .rd_data_o  (mem_wdata_o)
  );

  logic use_v1;
  assign use_v1     = (state == ST_RD1) || (state == ST_WR1);
  assign mem_req_o  = (state != ST_IDLE);
  assign mem_we_o   = (state == ST_WR2) || (state == ST_WR1);
  assign mem_addr_o = (use_v1 ? vaddr[0] : vaddr[1]) + AW'(widx);
endmodule

// File: rtl/vxe_chk.sv
module vxe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic mem_req_o,
  input logic mem_we_o
);
  // R8
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R4
  read_before_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> $past(mem_req_o));
  // R3
  write_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
endmodule

bind vec_xfer_engine vxe_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o)
);

// File: tb/vec_xfer_engine_test.sv
module vec_xfer_engine_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, swap_i = 1'b0, dbl_i = 1'b0;
  logic [15:0] v1_base_i = '0, v1_stride_i = '0, v2_base_i = '0, v2_stride_i = '0, count_i = '0;
  logic        busy_o, done_o, mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;

  always #4 clk_i = ~clk_i;

  vec_xfer_engine uut (.*);

  int errors = 0, checks = 0;
  logic [15:0] mem [1024];
  logic [15:0] ref_mem [1024];
  logic [15:0] rdata_q = '0;
  assign mem_rdata_i = rdata_q;

  logic [15:0] log_addr [600];
  logic        log_we   [600];
  logic [15:0] exp_addr [600];
  logic        exp_we   [600];
  int log_n, exp_n, cyc = 0, last_acc, first_acc, done_cnt, done_cyc, start_cyc;

  always @(posedge clk_i) begin
    cyc++;
    if (start_i && !busy_o) start_cyc = cyc;
    if (mem_req_o) begin
      if (log_n < 600) begin
        log_addr[log_n] = mem_addr_o;
        log_we[log_n]   = mem_we_o;
      end
      if (log_n == 0) first_acc = cyc;
      log_n++;
      last_acc = cyc;
      if (mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;
      else          rdata_q <= mem[mem_addr_o[9:0]];
    end
    if (done_o) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [15:0] a, input logic we);
    exp_addr[exp_n] = a;
    exp_we[exp_n]   = we;
    exp_n++;
  endtask

  // expected trace and final memory, from the requirements
  task automatic build_ref(input logic [15:0] b1, b2, input int s1, s2, n, input bit dbl, swp);
    logic [15:0] a1 = b1, a2 = b2;
    logic [15:0] t1 [4], t2 [4];
    int e = dbl ? 4 : 2;
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < e; k++) push_exp(a1 + 16'(k), 1'b0);
      for (int k = 0; k < e; k++) push_exp(a2 + 16'(k), 1'b0);
      for (int k = 0; k < e; k++) push_exp(a2 + 16'(k), 1'b1);
      if (swp) for (int k = 0; k < e; k++) push_exp(a1 + 16'(k), 1'b1);
      for (int k = 0; k < e; k++) begin
        t1[k] = ref_mem[10'(a1 + 16'(k))];
        t2[k] = ref_mem[10'(a2 + 16'(k))];
      end
      for (int k = 0; k < e; k++) ref_mem[10'(a2 + 16'(k))] = t1[k];
      if (swp) for (int k = 0; k < e; k++) ref_mem[10'(a1 + 16'(k))] = t2[k];
      a1 = a1 + 16'(s1 * e);
      a2 = a2 + 16'(s2 * e);
    end
  endtask

  task automatic run_job(input string tag, input logic [15:0] b1, b2, input int s1, s2, n,
                         input bit dbl, swp, input bit poke);
    int bad = 0, first_bad = -1, mbad = 0;
    @(negedge clk_i);
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 16'h5000 ^ 16'(i * 37);
      ref_mem[i] = mem[i];
    end
    build_ref(b1, b2, s1, s2, n, dbl, swp);
    log_n = 0; done_cnt = 0; done_cyc = -1; last_acc = -1; first_acc = -1; start_cyc = -1;
    v1_base_i = b1; v2_base_i = b2; v1_stride_i = 16'(s1); v2_stride_i = 16'(s2);
    count_i = 16'(n); dbl_i = dbl; swap_i = swp; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk_i);
      v1_base_i = 16'd700; v2_base_i = 16'd800; count_i = 16'd5; swap_i = ~swp;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    for (int t = 0; t < 3000 && done_cnt == 0; t++) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(done_cnt == 1, "R8", {tag, " done pulse count"}, done_cnt, 1);
    chk(!busy_o, "R8", {tag, " idle after done"}, int'(busy_o), 0);
    chk(log_n == exp_n, "R7", {tag, " access count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (log_addr[i] !== exp_addr[i] || log_we[i] !== exp_we[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    chk(bad == 0, "R4", {tag, " access order/address mismatches"}, bad, 0);
    if (first_bad >= 0)
      $display("  first mismatch at %0d: addr %0d we %0d, expected addr %0d we %0d", first_bad,
               log_addr[first_bad], log_we[first_bad], exp_addr[first_bad], exp_we[first_bad]);
    for (int i = 0; i < 1024; i++) if (mem[i] !== ref_mem[i]) mbad++;
    chk(mbad == 0, "R5", {tag, " memory words differing"}, mbad, 0);
    if (n > 0) begin
      chk(first_acc == start_cyc + 1, "R7", {tag, " first access cycle"}, first_acc, start_cyc + 1);
      chk(done_cyc == last_acc + 1, "R8", {tag, " done after last write"}, done_cyc, last_acc + 1);
    end else begin
      chk(done_cyc == start_cyc + 1, "R3", {tag, " zero-count done timing"}, done_cyc, start_cyc + 1);
    end
  endtask

  task automatic test_reset();
    chk(busy_o == 1'b0, "R8", "reset busy", int'(busy_o), 0);
    chk(done_o == 1'b0, "R8", "reset done", int'(done_o), 0);
    chk(mem_req_o == 1'b0, "R8", "reset req", int'(mem_req_o), 0);
  endtask

  // R1 R2 R6: move, 2-word elements, distinct strides
  task automatic test_move_single();
    run_job("R1 R6 move sgl", 16'd100, 16'd300, 1, 2, 3, 1'b0, 1'b0, 1'b0);
  endtask
  // R1 R5: swap, 4-word elements, negative stride
  task automatic test_swap_double();
    run_job("R5 R2 swap dbl", 16'd200, 16'd400, -1, 3, 2, 1'b1, 1'b1, 1'b0);
  endtask
  task automatic test_move_double();
    run_job("R1 move dbl", 16'd50, 16'd51, 2, 1, 1, 1'b1, 1'b0, 1'b0);
  endtask
  // R3: count zero and negative
  task automatic test_zero_count();
    run_job("R3 count 0", 16'd100, 16'd200, 1, 1, 0, 1'b0, 1'b1, 1'b0);
    run_job("R3 count -2", 16'd100, 16'd200, 1, 1, -2, 1'b1, 1'b0, 1'b0);
  endtask
  // R2 R5: zero stride on vector 2 makes later reads see earlier writes
  task automatic test_swap_zero_stride();
    run_job("R2 swap s2=0", 16'd600, 16'd900, -2, 0, 4, 1'b0, 1'b1, 1'b0);
  endtask
  // R9: start while busy ignored
  task automatic test_start_busy();
    run_job("R9 start busy", 16'd120, 16'd160, 1, 1, 3, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    test_reset();
    test_move_single();
    test_swap_double();
    test_move_double();
    test_zero_count();
    test_swap_zero_stride();
    test_start_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule